// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Memory Slave

This block is a word-wide storage slave sitting on a shared bus where address and data take turns on the same 16 wires. A 3-bit phase code, presented every cycle, says what the current bus cycle is for. The slave remembers the last address put on the bus and decides from it whether it owns the access. It then answers reads, captures writes that span two adjacent cycles, or stays silent.

Two features set it apart from a plain memory. First, in the indirect-address phase the selected slave places a stored word on the bus, and every slave, selected or not, takes that word as the address of the next access. Second, the interrupt-acknowledge phase is folded into an ordinary address phase by a small remap stage. The shared bus is split into an input, an output and an output enable. The window is set by a base address and a word count; the base must be aligned to the count, a power of two.

Top module: `mux_bus_slave`

## Requirements
- R1: Phase codes {bdir,bc2,bc1} are: idle 000, indirect-address 001, vector 010, read 011, address 100, write-first 101, write-second 110, interrupt-ack 111. In idle, bus_oe_o is low.
- R2: In the address phase, the value on bus_i becomes the latched address at the end of the cycle; the slave is selected when that address lies in [BASE, BASE+DEPTH).
- R3: In the read phase with a selected address, bus_oe_o is high and bus_o carries the word stored at that address, in the same cycle.
- R4: In the indirect-address phase, a selected slave drives its stored word, and at the end of the phase the value on bus_i, whoever drove it, becomes the latched address.
- R5: A write-first/write-second pair to a selected address stores the bus_i value exactly once; with LATE_CAPTURE=0 the store happens in write-first.
- R6: The interrupt-ack phase latches bus_i as an address exactly like the address phase.
- R7: In the vector phase the slave does not drive the bus and keeps its latched address.
- R8: The slave drives only in read and indirect-address phases, and never when the latched address is outside the window; writes outside the window leave memory unchanged (an address that aliases a window word in its low bits does not touch it).
- R9: While rst_ni is low bus_oe_o is low; after reset every word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phase_i | input | 3 | Bus phase code {bdir,bc2,bc1} |
| bus_i | input | DATA_W | Value currently on the shared bus |
| bus_o | output | DATA_W | Value the slave places on the bus |
| bus_oe_o | output | 1 | Slave drives the bus when high |

## Verification
The checker assumes a well-formed bus: a write-second phase always directly follows a write-first phase, and bus_i holds the same value across the two. It also takes bus_i to be the resolved bus, so when the slave drives, bus_i equals bus_o. The bench resolves the bus itself from bus_oe_o and always issues writes as an adjacent pair with constant data, so both assumptions hold for every stimulus row.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'b000,
    PH_INDIR = 3'b001,
    PH_VEC   = 3'b010,
    PH_READ  = 3'b011,
    PH_ADDR  = 3'b100,
    PH_WR1   = 3'b101,
    PH_WR2   = 3'b110,
    PH_IACK  = 3'b111
  } phase_e;

  typedef struct packed {
    logic take_addr;
    logic drive;
    logic wr_first;
    logic wr_second;
  } strobe_t;

  function automatic logic in_win(input int unsigned a, input int unsigned base,
                                  input int unsigned span);
    return (a >= base) && (a < base + span);
  endfunction
endpackage

// File: rtl/mbs_phase_remap.sv
module mbs_phase_remap
  import mbs_pkg::*;
(
  input  logic [2:0] phase_i,
  output strobe_t    strb_o
);
  phase_e ph_raw, ph;

  always_comb begin
    ph_raw = phase_e'(phase_i);
    // interrupt-ack is seen by this slave as a plain address phase
    ph = (ph_raw == PH_IACK) ? PH_ADDR : ph_raw;
    strb_o.take_addr = (ph == PH_ADDR) || (ph == PH_INDIR);
    strb_o.drive     = (ph == PH_READ) || (ph == PH_INDIR);
    strb_o.wr_first  = (ph == PH_WR1);
    strb_o.wr_second = (ph == PH_WR2);
  end
endmodule

// File: rtl/mbs_addr_latch.sv
module mbs_addr_latch #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [ADDR_W-1:0] bus_i,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_o <= '0;
    else if (take_i) addr_o <= bus_i;
  end
endmodule

// File: rtl/mbs_store.sv
module mbs_store #(
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned DEPTH        = 16,
  parameter bit          LATE_CAPTURE = 1'b0,
  localparam int unsigned AW          = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic              wr_first_i,
  input  logic              wr_second_i,
  input  logic [AW-1:0]     idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              commit_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic first_done_q;
  logic commit_first;

  generate
    if (LATE_CAPTURE) begin : g_late
      assign commit_first = 1'b0;
    end else begin : g_early
      assign commit_first = hit_i && wr_first_i;
    end
  endgenerate

  // second phase commits only when the first did not
  assign commit_o = commit_first || (hit_i && wr_second_i && !first_done_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) first_done_q <= 1'b0;
    else         first_done_q <= commit_first;
  end

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  mem_q[w] <= '0;
      else if (commit_o && (idx_i == AW'(w)))       mem_q[w] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/mux_bus_slave.sv
module mux_bus_slave
  import mbs_pkg::*;
#(
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned BASE         = 32'h0100,
  parameter int unsigned DEPTH        = 16,
  parameter bit          LATE_CAPTURE = 1'b0,
  localparam int unsigned AW          = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        phase_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic [DATA_W-1:0] bus_o,
  output logic              bus_oe_o
);
  strobe_t           strb;
  logic [DATA_W-1:0] addr_q;
  logic [DATA_W-1:0] rdata;
  logic              hit;
  logic              wr_en;

  mbs_phase_remap u_remap (
    .phase_i (phase_i),
    .strb_o  (strb)
  );

  mbs_addr_latch #(.ADDR_W(DATA_W)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .take_i (strb.take_addr),
    .bus_i  (bus_i),
    .addr_o (addr_q)
  );

  assign hit = in_win(32'(addr_q), BASE, DEPTH);

  mbs_store #(
    .DATA_W       (DATA_W),
    .DEPTH        (DEPTH),
    .LATE_CAPTURE (LATE_CAPTURE)
  ) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hit_i       (hit),
    .wr_first_i  (strb.wr_first),
    .wr_second_i (strb.wr_second),
    .idx_i       (addr_q[AW-1:0]),
    .wdata_i     (bus_i),
    .rdata_o     (rdata),
    .commit_o    (wr_en)
  );

  assign bus_oe_o = rst_ni && hit && strb.drive;
  assign bus_o    = bus_oe_o ? rdata : '0;
endmodule

// File: rtl/mbs_checker.sv
module mbs_checker #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        phase_i,
  input logic [DATA_W-1:0] bus_i,
  input logic              bus_oe_o,
  input logic [DATA_W-1:0] addr_q,
  input logic              wr_en
);
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == 3'b000) |-> !bus_oe_o);

  assert_drive_phases_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o |-> (phase_i == 3'b011 || phase_i == 3'b001));

  assert_addr_take_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == 3'b100) |=> (addr_q == $past(bus_i)));

  assert_indir_take_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == 3'b001) |=> (addr_q == $past(bus_i)));

  assert_iack_take_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == 3'b111) |=> (addr_q == $past(bus_i)));

  assert_vec_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == 3'b010) |=> $stable(addr_q));

  assert_vec_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == 3'b010) |-> !bus_oe_o);

  assert_write_once_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && phase_i == 3'b110) |-> !$past(wr_en));

  assert_pair_form_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == 3'b110) |-> ($past(phase_i) == 3'b101 && $stable(bus_i)));

  assert_reset_quiet_R9: assert property (@(posedge clk_i)
    !rst_ni |-> !bus_oe_o);
endmodule

bind mux_bus_slave mbs_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .phase_i  (phase_i),
  .bus_i    (bus_i),
  .bus_oe_o (bus_oe_o),
  .addr_q   (addr_q),
  .wr_en    (wr_en)
);

// File: tb/mux_bus_slave_test.sv
module mux_bus_slave_test;
  localparam int unsigned NV = 54;
  localparam logic [2:0] IDL = 3'b000, IND = 3'b001, VEC = 3'b010, RD = 3'b011,
                         AD = 3'b100, W1 = 3'b101, W2 = 3'b110, IAK = 3'b111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] phase = 3'b000;
  logic [15:0] drv = '0;
  logic [15:0] bus_in, bus_out;
  logic oe;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign bus_in = oe ? bus_out : drv;

  mux_bus_slave uut (
    .clk_i (clk), .rst_ni (rst_n), .phase_i (phase),
    .bus_i (bus_in), .bus_o (bus_out), .bus_oe_o (oe)
  );

  // {phase, drive, exp_oe, exp_out, req}
  localparam logic [39:0] VT [NV] = '{
    {AD,  16'h0103, 1'b0, 16'h0000, 4'd2}, // R2
    {IDL, 16'h0000, 1'b0, 16'h0000, 4'd1}, // R1
    {W1,  16'hA5A5, 1'b0, 16'h0000, 4'd5}, // R5
    {W2,  16'hA5A5, 1'b0, 16'h0000, 4'd5},
    {IDL, 16'h0000, 1'b0, 16'h0000, 4'd1},
    {AD,  16'h0103, 1'b0, 16'h0000, 4'd2},
    {IDL, 16'h0000, 1'b0, 16'h0000, 4'd1},
    {RD,  16'h0000, 1'b1, 16'hA5A5, 4'd3}, // R3
    {IDL, 16'h0000, 1'b0, 16'h0000, 4'd1},
    {AD,  16'h0105, 1'b0, 16'h0000, 4'd2},
    {IDL, 16'h0000, 1'b0, 16'h0000, 4'd1},
    {W1,  16'h0108, 1'b0, 16'h0000, 4'd5},
    {W2,  16'h0108, 1'b0, 16'h0000, 4'd5},
    {AD,  16'h0108, 1'b0, 16'h0000, 4'd2},
    {IDL, 16'h0000, 1'b0, 16'h0000, 4'd1},
    {W1,  16'h1234, 1'b0, 16'h0000, 4'd5},
    {W2,  16'h1234, 1'b0, 16'h0000, 4'd5},
    {AD,  16'h0105, 1'b0, 16'h0000, 4'd2},
    {IDL, 16'h0000, 1'b0, 16'h0000, 4'd1},
    {IND, 16'h0000, 1'b1, 16'h0108, 4'd4}, // R4 slave supplies next address
    {IDL, 16'h0000, 1'b0, 16'h0000, 4'd1},
    {RD,  16'h0000, 1'b1, 16'h1234, 4'd4},
    {AD,  16'h0203, 1'b0, 16'h0000, 4'd8}, // R8 alias of word 3
    {IDL, 16'h0000, 1'b0, 16'h0000, 4'd8},
    {W1,  16'hFFFF, 1'b0, 16'h0000, 4'd8},
    {W2,  16'hFFFF, 1'b0, 16'h0000, 4'd8},
    {RD,  16'h0000, 1'b0, 16'h0000, 4'd8},
    {AD,  16'h0103, 1'b0, 16'h0000, 4'd8},
    {IDL, 16'h0000, 1'b0, 16'h0000, 4'd8},
    {RD,  16'h0000, 1'b1, 16'hA5A5, 4'd8},
    {IAK, 16'h0108, 1'b0, 16'h0000, 4'd6}, // R6
    {IDL, 16'h0000, 1'b0, 16'h0000, 4'd6},
    {RD,  16'h0000, 1'b1, 16'h1234, 4'd6},
    {AD,  16'h0103, 1'b0, 16'h0000, 4'd7}, // R7
    {VEC, 16'h0108, 1'b0, 16'h0000, 4'd7},
    {IDL, 16'h0000, 1'b0, 16'h0000, 4'd7},
    {RD,  16'h0000, 1'b1, 16'hA5A5, 4'd7},
    {AD,  16'h0050, 1'b0, 16'h0000, 4'd4}, // R4 other device supplies address
    {IDL, 16'h0000, 1'b0, 16'h0000, 4'd4},
    {IND, 16'h0105, 1'b0, 16'h0000, 4'd4},
    {IDL, 16'h0000, 1'b0, 16'h0000, 4'd4},
    {RD,  16'h0000, 1'b1, 16'h0108, 4'd4},
    {AD,  16'h010F, 1'b0, 16'h0000, 4'd2}, // R2 top word of window
    {IDL, 16'h0000, 1'b0, 16'h0000, 4'd2},
    {W1,  16'h7777, 1'b0, 16'h0000, 4'd2},
    {W2,  16'h7777, 1'b0, 16'h0000, 4'd2},
    {IDL, 16'h0000, 1'b0, 16'h0000, 4'd2},
    {RD,  16'h0000, 1'b1, 16'h7777, 4'd2},
    {AD,  16'h0110, 1'b0, 16'h0000, 4'd2}, // just above window
    {IDL, 16'h0000, 1'b0, 16'h0000, 4'd2},
    {RD,  16'h0000, 1'b0, 16'h0000, 4'd2},
    {AD,  16'h00FF, 1'b0, 16'h0000, 4'd2}, // just below window
    {IDL, 16'h0000, 1'b0, 16'h0000, 4'd2},
    {RD,  16'h0000, 1'b0, 16'h0000, 4'd2}
  };

  task automatic check(input int req, input logic a_oe, input logic [15:0] a_out,
                       input logic e_oe, input logic [15:0] e_out);
    checks++;
    if (a_oe !== e_oe || (e_oe && a_out !== e_out)) begin
      fails++;
      $display("FAIL R%0d: oe=%0b out=%h, expected oe=%0b out=%h",
               req, a_oe, a_out, e_oe, e_out);
    end
  endtask

  // drive at falling edge, sample before the next rising edge
  task automatic step(input logic [2:0] ph, input logic [15:0] d,
                      input int req, input logic e_oe, input logic [15:0] e_out);
    @(negedge clk);
    phase = ph;
    drv = d;
    #1;
    check(req, oe, bus_out, e_oe, e_out);
  endtask

  initial begin
    // R9: no drive during reset even in a read phase
    @(negedge clk);
    phase = RD;
    #1;
    check(9, oe, bus_out, 1'b0, 16'h0000);
    @(negedge clk);
    phase = IDL;
    rst_n = 1'b1;
    // R9: memory cleared
    step(AD, 16'h0100, 9, 1'b0, 16'h0000);
    step(IDL, 16'h0000, 9, 1'b0, 16'h0000);
    step(RD, 16'h0000, 9, 1'b1, 16'h0000);
    step(IDL, 16'h0000, 9, 1'b0, 16'h0000);

    for (int i = 0; i < NV; i++)
      step(VT[i][39:37], VT[i][36:21], int'(VT[i][3:0]), VT[i][20], VT[i][19:4]);

    // R5: back-to-back pair then immediate read of lowest word
    step(AD, 16'h0100, 5, 1'b0, 16'h0000);
    step(W1, 16'h0F0F, 5, 1'b0, 16'h0000);
    step(W2, 16'h0F0F, 5, 1'b0, 16'h0000);
    step(RD, 16'h0000, 5, 1'b1, 16'h0F0F);
    // R8: read stays quiet in a write phase
    step(W1, 16'h0F0F, 8, 1'b0, 16'h0000);
    step(W2, 16'h0F0F, 8, 1'b0, 16'h0000);
    step(IDL, 16'h0000, 1, 1'b0, 16'h0000);
    // R9: reset mid-run clears stored words
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(9, oe, bus_out, 1'b0, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    step(AD, 16'h0103, 9, 1'b0, 16'h0000);
    step(IDL, 16'h0000, 9, 1'b0, 16'h0000);
    step(RD, 16'h0000, 9, 1'b1, 16'h0000);
    step(IDL, 16'h0000, 9, 1'b0, 16'h0000);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule